// File: doc/BRIEF.md
# Centralized Scoreboard Hazard Controller

This block is the central control for a small group of floating-point execution units. It decides when each instruction may enter a unit, when it may fetch its two source registers, and when it may store its result. Instructions come in program order on a valid/ready port. Each instruction carries a unit class, an opcode, one destination register and two source registers. The controller places the instruction into a free unit of that class. It then raises a read grant toward that unit once both sources hold final values. When the unit signals that its computation is done, the controller raises a write grant, but only when the write is safe.

There is no bypass path. A consumer fetches a produced value only from the register file, which means at least one cycle after the producer's write grant. The controller handles three hazards. A busy unit stalls issue. A destination that is already pending stalls issue. A result is held back while an older instruction that has not yet read its operands still needs the current contents of that register.

The default configuration has five units, each known by a 3-bit tag: one integer/load unit (tag 1), two multipliers (tags 2 and 3), one adder (tag 4) and one divider (tag 5). The datapaths are outside the block.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: During and right after reset, every unit is idle. `iss_ready` is 1, and `iss_tag` equals the first unit of the presented class. No read or write grant is active.
- R2: Class encoding: 0 means integer/load, 1 multiply, 2 add, 3 divide. An instruction goes to the lowest-tag idle unit of its class. If no unit of that class is idle, `iss_ready` is 0 and `iss_tag` is 0.
- R3: `iss_ready` is 0 while any in-flight instruction has not yet been granted its write to the presented destination register.
- R4: Issue is strictly in order. An instruction is accepted only in a cycle where `iss_valid` and `iss_ready` are both 1, and a stalled head holds back every later instruction.
- R5: A unit's read grant is raised for exactly one cycle per instruction. It comes only once no source of that instruction waits on an unwritten producer.
- R6: A producer whose write grant falls in the issue cycle counts as written. A waiting consumer gets its read grant no earlier than the cycle after its producer's write grant.
- R7: A write grant is withheld while any other unit holds an instruction that has not read its operands yet, names the result register as a source, and has that source marked ready.
- R8: `fu_done` takes effect only for a unit that has been granted its read and has not yet signalled done. In every other state it is ignored. A write grant requires an earlier done.
- R9: After its write grant, a unit is idle and its destination register is free for new issue in the next cycle.
- R10: While a unit is busy, its slice of `fu_op` (bits tag-1 times the op width) shows the opcode accepted at issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction present at head |
| iss_ready | output | 1 | Head instruction may issue this cycle |
| iss_cls | input | 2 | Unit class of head instruction |
| iss_op | input | 4 | Opcode of head instruction |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_tag | output | 3 | Tag of the unit chosen (0 if none) |
| rd_grant | output | 5 | Per-unit operand read grant |
| fu_done | input | 5 | Per-unit execution complete pulse |
| wr_grant | output | 5 | Per-unit result write grant |
| fu_op | output | 20 | Opcode held by each unit, 4 bits per unit |

## Verification
The bench first drives independent instructions, which shows whether units of different classes work in parallel. It then runs a dependent chain, which separates correct read-after-write waiting from premature reads. A long divide followed by a short add to the same register exposes the destination stall. A divide blocked on one source, with an add that targets its other source, can only pass if the write is held back. Three back-to-back multiplies test the second multiplier and the structural stall. Stray done pulses on idle and waiting units check that they are ignored. A long pseudo-random stream with issue bubbles brings up same-cycle write and issue races, which the cycle-accurate reference model must match on every output.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int CLS_W = 2;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2,
    ST_RES  = 2'd3
  } sb_stage_e;
endpackage

// File: rtl/sb_issue_sel.sv
module sb_issue_sel
  import sb_pkg::*;
#(
  parameter int N_INT  = 1,
  parameter int N_MUL  = 2,
  parameter int N_ADD  = 1,
  parameter int N_DIV  = 1,
  parameter int NUM_FU = N_INT + N_MUL + N_ADD + N_DIV
) (
  input  logic [CLS_W-1:0]  cls,
  input  logic [NUM_FU-1:0] busy,
  output logic              hit,
  output logic [NUM_FU-1:0] pick
);
  localparam int B_MUL = N_INT;
  localparam int B_ADD = N_INT + N_MUL;
  localparam int B_DIV = N_INT + N_MUL + N_ADD;

  logic [NUM_FU-1:0] cand;

  for (genvar g = 0; g < NUM_FU; g++) begin : g_cand
    localparam logic [CLS_W-1:0] UCLS = (g < B_MUL) ? 2'd0 :
                                        (g < B_ADD) ? 2'd1 :
                                        (g < B_DIV) ? 2'd2 : 2'd3;
    assign cand[g] = (cls == UCLS) && !busy[g];
  end

  // lowest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (cand[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
    hit = found;
  end
endmodule

// File: rtl/sb_unit_slot.sv
module sb_unit_slot
  import sb_pkg::*;
#(
  parameter int REG_W  = 3,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3,
  parameter int NUM_FU = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   a_op,
  input  logic [REG_W-1:0]  a_fi,
  input  logic [REG_W-1:0]  a_fj,
  input  logic [REG_W-1:0]  a_fk,
  input  logic [TAG_W-1:0]  a_qj,
  input  logic [TAG_W-1:0]  a_qk,
  input  logic [NUM_FU-1:0] wr_vec,
  input  logic              done,
  input  logic              wr_ok,
  output sb_stage_e         stage,
  output logic [OP_W-1:0]   op,
  output logic [REG_W-1:0]  fi,
  output logic [REG_W-1:0]  fj,
  output logic [REG_W-1:0]  fk,
  output logic              rj,
  output logic              rk,
  output logic              rd_grant,
  output logic              wr_grant
);
  sb_stage_e        stage_q, stage_d;
  logic [OP_W-1:0]  op_q, op_d;
  logic [REG_W-1:0] fi_q, fi_d, fj_q, fj_d, fk_q, fk_d;
  logic [TAG_W-1:0] qj_q, qj_d, qk_q, qk_d;
  logic             rj_q, rj_d, rk_q, rk_d;
  logic             hit_j, hit_k;

  always_comb begin
    hit_j = 1'b0;
    hit_k = 1'b0;
    for (int t = 0; t < NUM_FU; t++) begin
      if (wr_vec[t] && qj_q == TAG_W'(t + 1)) hit_j = 1'b1;
      if (wr_vec[t] && qk_q == TAG_W'(t + 1)) hit_k = 1'b1;
    end
  end

  assign rd_grant = (stage_q == ST_WAIT) && rj_q && rk_q;
  assign wr_grant = (stage_q == ST_RES) && wr_ok;

  always_comb begin
    stage_d = stage_q;
    op_d = op_q; fi_d = fi_q; fj_d = fj_q; fk_d = fk_q;
    qj_d = qj_q; qk_d = qk_q; rj_d = rj_q; rk_d = rk_q;
    unique case (stage_q)
      ST_IDLE: if (alloc) begin
        stage_d = ST_WAIT;
        op_d = a_op; fi_d = a_fi; fj_d = a_fj; fk_d = a_fk;
        qj_d = a_qj; qk_d = a_qk;
        rj_d = (a_qj == '0);
        rk_d = (a_qk == '0);
      end
      ST_WAIT: begin
        if (hit_j) begin qj_d = '0; rj_d = 1'b1; end
        if (hit_k) begin qk_d = '0; rk_d = 1'b1; end
        if (rd_grant) begin
          stage_d = ST_EXEC;
          rj_d = 1'b0;
          rk_d = 1'b0;
        end
      end
      ST_EXEC: if (done) stage_d = ST_RES;
      ST_RES:  if (wr_grant) stage_d = ST_IDLE;
      default: stage_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      op_q <= '0; fi_q <= '0; fj_q <= '0; fk_q <= '0;
      qj_q <= '0; qk_q <= '0; rj_q <= 1'b0; rk_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      op_q <= op_d; fi_q <= fi_d; fj_q <= fj_d; fk_q <= fk_d;
      qj_q <= qj_d; qk_q <= qk_d; rj_q <= rj_d; rk_q <= rk_d;
    end
  end

  assign stage = stage_q;
  assign op = op_q;
  assign fi = fi_q;
  assign fj = fj_q;
  assign fk = fk_q;
  assign rj = rj_q;
  assign rk = rk_q;
endmodule

// File: rtl/sb_hazard_ctrl.sv
module sb_hazard_ctrl
  import sb_pkg::*;
#(
  parameter int N_INT = 1,
  parameter int N_MUL = 2,
  parameter int N_ADD = 1,
  parameter int N_DIV = 1,
  parameter int REG_W = 3,
  parameter int OP_W  = 4,
  localparam int NUM_FU = N_INT + N_MUL + N_ADD + N_DIV,
  localparam int TAG_W  = $clog2(NUM_FU + 1),
  localparam int NREG   = 1 << REG_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   iss_valid,
  output logic                   iss_ready,
  input  logic [CLS_W-1:0]       iss_cls,
  input  logic [OP_W-1:0]        iss_op,
  input  logic [REG_W-1:0]       iss_dst,
  input  logic [REG_W-1:0]       iss_src1,
  input  logic [REG_W-1:0]       iss_src2,
  output logic [TAG_W-1:0]       iss_tag,
  output logic [NUM_FU-1:0]      rd_grant,
  input  logic [NUM_FU-1:0]      fu_done,
  output logic [NUM_FU-1:0]      wr_grant,
  output logic [NUM_FU*OP_W-1:0] fu_op
);
  sb_stage_e        stage_v [NUM_FU];
  logic [REG_W-1:0] fi_v [NUM_FU];
  logic [REG_W-1:0] fj_v [NUM_FU];
  logic [REG_W-1:0] fk_v [NUM_FU];
  logic [NUM_FU-1:0] rj_v, rk_v, busy_v, pick, war_ok;
  logic              sel_hit, fire, dst_pend;
  logic [TAG_W-1:0]  regstat_q [NREG];
  logic [TAG_W-1:0]  regstat_d [NREG];
  logic [TAG_W-1:0]  q1, q2;

  sb_issue_sel #(
    .N_INT(N_INT), .N_MUL(N_MUL), .N_ADD(N_ADD), .N_DIV(N_DIV), .NUM_FU(NUM_FU)
  ) i_sel (
    .cls(iss_cls), .busy(busy_v), .hit(sel_hit), .pick(pick)
  );

  assign dst_pend  = (regstat_q[iss_dst] != '0);
  assign iss_ready = sel_hit && !dst_pend;
  assign fire      = iss_valid && iss_ready;

  always_comb begin
    iss_tag = '0;
    for (int i = 0; i < NUM_FU; i++)
      if (pick[i]) iss_tag = TAG_W'(i + 1);
  end

  // producer tags for the new entry; a write in this same cycle counts as done
  always_comb begin
    q1 = regstat_q[iss_src1];
    q2 = regstat_q[iss_src2];
    for (int t = 0; t < NUM_FU; t++) begin
      if (wr_grant[t] && q1 == TAG_W'(t + 1)) q1 = '0;
      if (wr_grant[t] && q2 == TAG_W'(t + 1)) q2 = '0;
    end
  end

  for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
    // write-after-read guard: no waiting reader may still want the old value
    always_comb begin
      war_ok[u] = 1'b1;
      for (int f = 0; f < NUM_FU; f++) begin
        if (f != u && stage_v[f] == ST_WAIT &&
            ((fj_v[f] == fi_v[u] && rj_v[f]) || (fk_v[f] == fi_v[u] && rk_v[f])))
          war_ok[u] = 1'b0;
      end
    end

    sb_unit_slot #(
      .REG_W(REG_W), .OP_W(OP_W), .TAG_W(TAG_W), .NUM_FU(NUM_FU)
    ) i_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc(fire && pick[u]),
      .a_op(iss_op), .a_fi(iss_dst), .a_fj(iss_src1), .a_fk(iss_src2),
      .a_qj(q1), .a_qk(q2),
      .wr_vec(wr_grant), .done(fu_done[u]), .wr_ok(war_ok[u]),
      .stage(stage_v[u]), .op(fu_op[u*OP_W +: OP_W]),
      .fi(fi_v[u]), .fj(fj_v[u]), .fk(fk_v[u]),
      .rj(rj_v[u]), .rk(rk_v[u]),
      .rd_grant(rd_grant[u]), .wr_grant(wr_grant[u])
    );

    assign busy_v[u] = (stage_v[u] != ST_IDLE);
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      regstat_d[r] = regstat_q[r];
      for (int u = 0; u < NUM_FU; u++)
        if (wr_grant[u] && fi_v[u] == REG_W'(r)) regstat_d[r] = '0;
      if (fire && iss_dst == REG_W'(r)) regstat_d[r] = iss_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regstat_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) regstat_q[r] <= regstat_d[r];
    end
  end
endmodule

// File: rtl/sb_hazard_chk.sv
module sb_hazard_chk #(
  parameter int NUM_FU = 5,
  parameter int TAG_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [TAG_W-1:0]  iss_tag,
  input logic [NUM_FU-1:0] busy_v,
  input logic [NUM_FU-1:0] rd_grant,
  input logic [NUM_FU-1:0] wr_grant
);
  logic [NUM_FU-1:0] tag_hot, seen_rd;

  always_comb begin
    tag_hot = '0;
    for (int i = 0; i < NUM_FU; i++)
      if (iss_tag == TAG_W'(i + 1)) tag_hot[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_rd <= '0;
    else        seen_rd <= (seen_rd | rd_grant) & ~wr_grant;
  end

  // R2: an accepted instruction lands in an idle unit
  p_issue_idle_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |-> ((tag_hot != '0) && ((tag_hot & busy_v) == '0)));

  // R5: one read grant per instruction, never twice in a row
  p_read_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant != '0) |=> ((rd_grant & $past(rd_grant)) == '0));

  // R8: a write grant is preceded by a read grant for the same unit
  p_write_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant & ~seen_rd) == '0);

  // R9: the written unit is idle on the next cycle
  p_free_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant != '0) |=> ((busy_v & $past(wr_grant)) == '0));
endmodule

bind sb_hazard_ctrl sb_hazard_chk #(.NUM_FU(NUM_FU), .TAG_W(TAG_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_tag(iss_tag), .busy_v(busy_v), .rd_grant(rd_grant), .wr_grant(wr_grant)
);

// File: tb/test_sb_hazard_ctrl.sv
`timescale 1ns/1ps
module test_sb_hazard_ctrl;
  localparam int NF = 5;
  localparam int OPW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic iss_ready;
  logic [1:0] iss_cls = '0;
  logic [3:0] iss_op = '0;
  logic [2:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
  logic [2:0] iss_tag;
  logic [NF-1:0] rd_grant, wr_grant;
  logic [NF-1:0] fu_done = '0;
  logic [NF*OPW-1:0] fu_op;

  always #4 clk = ~clk;

  sb_hazard_ctrl i_sb_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_cls(iss_cls), .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1),
    .iss_src2(iss_src2), .iss_tag(iss_tag), .rd_grant(rd_grant),
    .fu_done(fu_done), .wr_grant(wr_grant), .fu_op(fu_op)
  );

  typedef struct { int cls; int op; int d; int s1; int s2; } ins_t;
  ins_t prog[$];

  int ucls[NF] = '{0, 1, 1, 2, 3};
  int lat[NF]  = '{1, 4, 4, 2, 10};
  int m_st[NF], m_fi[NF], m_fj[NF], m_fk[NF], m_qj[NF], m_qk[NF];
  int m_rj[NF], m_rk[NF], m_op[NF], m_cnt[NF], m_done[NF];
  int regst[8];
  int e_ready, e_tag;
  int e_rd[NF], e_wr[NF];
  int vectors = 0, miscompares = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic push(int c, int o, int d, int a, int b);
    ins_t x;
    x.cls = c; x.op = o; x.d = d; x.s1 = a; x.s2 = b;
    prog.push_back(x);
  endtask

  task automatic eval();
    e_tag = 0;
    for (int u = 0; u < NF; u++)
      if (e_tag == 0 && ucls[u] == int'(iss_cls) && m_st[u] == 0) e_tag = u + 1;
    e_ready = (e_tag != 0 && regst[iss_dst] == 0) ? 1 : 0;
    for (int u = 0; u < NF; u++) begin
      e_rd[u] = (m_st[u] == 1 && m_rj[u] == 1 && m_rk[u] == 1) ? 1 : 0;
      e_wr[u] = (m_st[u] == 3) ? 1 : 0;
      for (int f = 0; f < NF; f++)
        if (f != u && m_st[f] == 1 && m_st[u] == 3 &&
            ((m_fj[f] == m_fi[u] && m_rj[f] == 1) || (m_fk[f] == m_fi[u] && m_rk[f] == 1)))
          e_wr[u] = 0;
    end
  endtask

  task automatic compare();
    chk("R2 R3 R4 issue ready", int'(iss_ready), e_ready);
    chk("R2 unit tag", int'(iss_tag), e_tag);
    for (int u = 0; u < NF; u++) begin
      chk("R5 R6 read grant", int'(rd_grant[u]), e_rd[u]);
      chk("R7 R8 R9 write grant", int'(wr_grant[u]), e_wr[u]);
      if (m_st[u] != 0) chk("R10 unit op", int'(fu_op[u*OPW +: OPW]), m_op[u]);
    end
  endtask

  task automatic step_model();
    int fire, u, n1, n2, p;
    fire = (iss_valid && e_ready) ? 1 : 0;
    n1 = 0; n2 = 0;
    if (fire == 1) begin
      p = regst[iss_src1];
      if (p != 0 && e_wr[p-1] == 0) n1 = p;
      p = regst[iss_src2];
      if (p != 0 && e_wr[p-1] == 0) n2 = p;
    end
    for (int w = 0; w < NF; w++) begin
      if (e_wr[w] == 1) begin
        regst[m_fi[w]] = 0;
        m_st[w] = 0;
        for (int f = 0; f < NF; f++) begin
          if (m_qj[f] == w + 1) begin m_qj[f] = 0; m_rj[f] = 1; end
          if (m_qk[f] == w + 1) begin m_qk[f] = 0; m_rk[f] = 1; end
        end
      end
    end
    for (int x = 0; x < NF; x++) begin
      if (m_st[x] == 2) begin
        if (m_done[x] == 1) m_st[x] = 3;
        else if (m_cnt[x] > 0) m_cnt[x]--;
      end
      if (e_rd[x] == 1) begin
        m_st[x] = 2; m_rj[x] = 0; m_rk[x] = 0; m_cnt[x] = lat[x] - 1;
      end
    end
    if (fire == 1) begin
      u = e_tag - 1;
      m_st[u] = 1; m_op[u] = int'(iss_op);
      m_fi[u] = int'(iss_dst); m_fj[u] = int'(iss_src1); m_fk[u] = int'(iss_src2);
      m_qj[u] = n1; m_qk[u] = n2;
      m_rj[u] = (n1 == 0) ? 1 : 0; m_rk[u] = (n2 == 0) ? 1 : 0;
      regst[iss_dst] = e_tag;
      void'(prog.pop_front());
    end
  endtask

  task automatic drive();
    logic [NF-1:0] dn;
    dn = '0;
    for (int u = 0; u < NF; u++) begin
      m_done[u] = (m_st[u] == 2 && m_cnt[u] == 0) ? 1 : 0;
      if (m_done[u] == 1) dn[u] = 1'b1;
      // R8: stray completion pulses on idle or waiting units must be ignored
      if (m_st[u] <= 1 && (cyc + u) % 7 == 0) dn[u] = 1'b1;
    end
    fu_done <= dn;
    if (prog.size() > 0 && (cyc % 11) != 3) begin
      iss_valid <= 1'b1;
      iss_cls <= 2'(prog[0].cls); iss_op <= 4'(prog[0].op);
      iss_dst <= 3'(prog[0].d); iss_src1 <= 3'(prog[0].s1); iss_src2 <= 3'(prog[0].s2);
    end else begin
      iss_valid <= 1'b0;
    end
  endtask

  function automatic int all_idle();
    for (int u = 0; u < NF; u++) if (m_st[u] != 0) return 0;
    return 1;
  endfunction

  initial begin
    for (int u = 0; u < NF; u++) begin
      m_st[u] = 0; m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0; m_qj[u] = 0; m_qk[u] = 0;
      m_rj[u] = 0; m_rk[u] = 0; m_op[u] = 0; m_cnt[u] = 0; m_done[u] = 0;
    end
    for (int r = 0; r < 8; r++) regst[r] = 0;

    // independent work across classes
    push(0, 1, 1, 2, 3); push(2, 2, 4, 5, 6); push(1, 3, 5, 6, 7); push(3, 4, 6, 7, 1);
    // dependent chain (read after write)
    push(1, 5, 0, 1, 2); push(2, 6, 3, 0, 4); push(3, 7, 5, 3, 0);
    // destination stall: long divide then add to the same register
    push(3, 8, 6, 1, 2); push(2, 9, 6, 3, 3);
    // write-after-read: divide waits on f2, add targets its other source f6
    push(1, 10, 2, 1, 1); push(3, 11, 3, 2, 6); push(2, 12, 6, 1, 1);
    // structural: three multiplies then integer
    push(1, 13, 1, 4, 4); push(1, 14, 4, 5, 5); push(1, 15, 7, 0, 0); push(0, 0, 0, 7, 7);
    for (int i = 0; i < 160; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push(int'(lfsr[1:0]), int'(lfsr[5:2]), int'(lfsr[8:6]), int'(lfsr[11:9]), int'(lfsr[14:12]));
    end

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", int'(iss_ready), 1);
    chk("R1 tag in reset", int'(iss_tag), 1);
    chk("R1 no read grant", int'(rd_grant), 0);
    chk("R1 no write grant", int'(wr_grant), 0);
    rst_n = 1'b1;
    @(negedge clk);
    eval();
    compare();

    while (prog.size() > 0 || all_idle() == 0) begin
      @(posedge clk);
      step_model();
      cyc++;
      #1;
      drive();
      @(negedge clk);
      eval();
      compare();
      if (cyc > 20000) begin
        miscompares++;
        vectors++;
        $display("FAIL watchdog: actual %0d cycles expected completion, R4", cyc);
        break;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule